// File: doc/BRIEF.md
# Deferred Condition-Code Flag Evaluator

This block holds the three values a processor core keeps in place of ready-made condition flags: an operation class, one source operand and the result of the operation. From these it rebuilds the negative (N), zero (Z), overflow (V) and carry (C) flags on request. The core loads the triple when an instruction finishes. It reads the flags only when a branch or a status read needs them.

The packed flag word is always visible at the output and is computed from the stored triple without a clock. A flush strobe writes that word back into the stored result and marks the class as final, so later reads pass the word through unchanged. Carry and overflow are rebuilt from the stored result and the one saved operand, not from a live adder. The shift classes treat counts of 32 and above explicitly.

Class codes: 0 final, 1 logical, 2 add, 3 subtract, 4 byte compare, 5 word compare, 6 add-with-extend, 7 subtract-with-extend, 8 logical left shift, 9 logical right shift, 10 arithmetic right shift. Codes 11 to 15 are undefined. In the packed word, C is bit 0, V is bit 1, Z is bit 2 and N is bit 3, and bits 31:4 are zero.

Top module: `ccflag_eval`

## Requirements
- R1: After reset the stored class is 0 (final), the stored result and source are 0, `flags_o` is 0 and `err_o` is 0.
- R2: A load with a defined code (0 to 10) stores the class, source and result on the clock edge. While the class is 0, `flags_o` equals the stored result unchanged. For every other class, `flags_o` is {28'b0, N, Z, V, C}, with C at bit 0, V at bit 1, Z at bit 2 and N at bit 3.
- R3: Z (bit 2) is 1 exactly when the tested value is zero. N (bit 3) is 1 only when the tested value is non-zero and its top bit is 1.
- R4: Class 1 (logical) takes N and Z from the result; C and V (bits 0 and 1) are 0.
- R5: Class 2 (add): C = result < source (unsigned). With other = result − source, V = bit 31 of (source ^ result) & ~(other ^ source).
- R6: Class 3 (subtract): with m = result + source, C = m < source (unsigned) and V = bit 31 of (m ^ result) & (m ^ source).
- R7: Classes 4 and 5 apply the subtract rule at 8 and 16 bits. N and Z use the truncated result. C and V use the truncated values and the bit 7 or bit 15 sign position.
- R8: Class 6 (add-with-extend): C = result <= source, other = result − source − 1, and V follows the add formula. Class 7 (subtract-with-extend): m = result + source + 1, C = m <= source, and V follows the subtract formula.
- R9: For shift classes 8, 9 and 10, a count (the source) of 32 or more gives Z=1, N=0 for classes 8 and 9, and N=1, Z=0 for class 10. Below 32, N and Z come from the shifted result. V is 0.
- R10: A shift's C is 0 unless the count is between 1 and 32 inclusive. In that range it is bit (32 − count) of the result for a left shift, and bit (count − 1) of the sign-extended result for a right shift.
- R11: A flush (`flush_i` without `load_i`) writes `flags_o` into the stored result and sets the class to 0 on the next edge. When both strobes are high, the load wins.
- R12: A load with an undefined code (11 to 15) leaves the class, source and result unchanged and sets `err_o` to 1 for the following cycle. `err_o` is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Store a new class, source and result |
| op_i | input | 4 | Operation class code to store |
| src_i | input | 32 | Source operand to store (the count for shifts) |
| res_i | input | 32 | Result value to store |
| flush_i | input | 1 | Write the packed flag word back and set the class to final |
| flags_o | output | 32 | Current flag word |
| cls_o | output | 4 | Stored operation class |
| res_o | output | 32 | Stored result |
| err_o | output | 1 | Undefined code was offered on the previous load |

## Verification
The bench targets the signed-overflow boundaries of add and subtract, such as 0x7FFFFFFF + 1 and 0x80000000 − 1. A design that reads the sign bit from the wrong term reports V on the wrong side of those boundaries. Shift counts of 0, 1, 31, 32, 33 and very large values probe the count window: an off-by-one index moves C by one bit, and a missing limit check lets C or N/Z follow a wrapped shift. Byte and word compares use operands whose upper bits would set flags at 32 bits, so a design that ignores the truncation fails. The flush/load collision, the flush of a class that is already final, and undefined codes show whether the stored state is overwritten when it should be kept.

// File: rtl/ccflag_eval.sv
module ccflag_eval #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] res_i,
  input  logic         flush_i,
  output logic [W-1:0] flags_o,
  output logic [3:0]   cls_o,
  output logic [W-1:0] res_o,
  output logic         err_o
);
  localparam int CW = $clog2(W);
  localparam logic [W-1:0] WLIM = W;
  localparam logic [3:0] C_FIN = 4'd0, C_LOG = 4'd1, C_ADD = 4'd2, C_SUB = 4'd3,
                         C_CMB = 4'd4, C_CMW = 4'd5, C_ADX = 4'd6, C_SBX = 4'd7,
                         C_SHL = 4'd8, C_SHR = 4'd9, C_SAR = 4'd10;

  logic [3:0]   cls_q;
  logic [W-1:0] src_q, res_q;
  logic         err_q;
  logic         n, z, v, c;
  logic [W-1:0] tv, ix;
  logic         bad_op;

  assign bad_op = op_i > C_SAR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cls_q <= C_FIN;
      src_q <= '0;
      res_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= load_i && bad_op;
      if (load_i) begin
        if (!bad_op) begin
          cls_q <= op_i;
          src_q <= src_i;
          res_q <= res_i;
        end
      end else if (flush_i) begin
        res_q <= flags_o;
        cls_q <= C_FIN;
      end
    end
  end

  always_comb begin
    n = 1'b0; z = 1'b0; v = 1'b0; c = 1'b0;
    tv = '0;
    ix = '0;
    unique case (cls_q)
      C_LOG: begin
        z = (res_q == '0); n = !z && res_q[W-1];
      end
      C_ADD, C_ADX: begin
        z = (res_q == '0); n = !z && res_q[W-1];
        tv = res_q - src_q - ((cls_q == C_ADX) ? 1 : 0);
        c = (cls_q == C_ADX) ? (res_q <= src_q) : (res_q < src_q);
        v = src_q[W-1] ^ res_q[W-1] && !(tv[W-1] ^ src_q[W-1]);
      end
      C_SUB, C_SBX: begin
        z = (res_q == '0); n = !z && res_q[W-1];
        tv = res_q + src_q + ((cls_q == C_SBX) ? 1 : 0);
        c = (cls_q == C_SBX) ? (tv <= src_q) : (tv < src_q);
        v = (tv[W-1] ^ res_q[W-1]) && (tv[W-1] ^ src_q[W-1]);
      end
      C_CMB: begin
        tv = res_q + src_q;
        z = (res_q[7:0] == 8'd0); n = !z && res_q[7];
        c = tv[7:0] < src_q[7:0];
        v = (tv[7] ^ res_q[7]) && (tv[7] ^ src_q[7]);
      end
      C_CMW: begin
        tv = res_q + src_q;
        z = (res_q[15:0] == 16'd0); n = !z && res_q[15];
        c = tv[15:0] < src_q[15:0];
        v = (tv[15] ^ res_q[15]) && (tv[15] ^ src_q[15]);
      end
      C_SHL, C_SHR, C_SAR: begin
        if (src_q >= WLIM) begin
          z = (cls_q != C_SAR);
          n = (cls_q == C_SAR);
        end else begin
          if (cls_q == C_SHL)      tv = res_q << src_q[CW-1:0];
          else if (cls_q == C_SHR) tv = res_q >> src_q[CW-1:0];
          else                     tv = $signed(res_q) >>> src_q[CW-1:0];
          z = (tv == '0); n = !z && tv[W-1];
        end
        ix = (cls_q == C_SHL) ? (WLIM - src_q) : (src_q - 1);
        // within the count window the sign-extended bit (count-1) is a real operand bit
        c = (src_q != '0) && (src_q <= WLIM) && res_q[ix[CW-1:0]];
      end
      default: ;
    endcase
  end

  assign flags_o = (cls_q == C_FIN) ? res_q : {{(W-4){1'b0}}, n, z, v, c};
  assign cls_o   = cls_q;
  assign res_o   = res_q;
  assign err_o   = err_q;

  // R11
  flush_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && !load_i && cls_q != C_FIN) |=> (cls_q == C_FIN && res_q[W-1:4] == '0));

  // R11
  flush_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && !load_i && cls_q == C_FIN) |=> $stable(res_q));

  // R12
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && op_i > C_SAR) |=> (err_o && $stable(cls_q) && $stable(res_q) && $stable(src_q)));

  // R12
  cls_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cls_q <= C_SAR);

  // R3
  nz_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_q != C_FIN) |-> !(flags_o[3] && flags_o[2]));

  // R4
  logic_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_q == C_LOG) |-> (flags_o[1:0] == 2'b00));

  // R10
  shift_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cls_q == C_SHL || cls_q == C_SHR || cls_q == C_SAR) && (src_q == '0 || src_q > WLIM))
      |-> (flags_o[0] == 1'b0));
endmodule

// File: tb/tb_ccflag_eval.sv
module tb_ccflag_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] src_i = '0, res_i = '0;
  logic        flush_i = 1'b0;
  logic [31:0] flags_o, res_o;
  logic [3:0]  cls_o;
  logic        err_o;
  int checks = 0, fails = 0;
  bit done = 0;

  ccflag_eval dut (.clk(clk), .rst_n(rst_n), .load_i(load_i), .op_i(op_i), .src_i(src_i),
    .res_i(res_i), .flush_i(flush_i), .flags_o(flags_o), .cls_o(cls_o), .res_o(res_o), .err_o(err_o));

  always #10 clk = ~clk;

  function automatic logic [31:0] ref_flags(input logic [3:0] op, input logic [31:0] s, input logic [31:0] r);
    logic n, z, v, c;
    logic [31:0] o, t;
    logic [32:0] w;
    logic [95:0] x;
    n = 0; z = 0; v = 0; c = 0;
    if (op == 0) return r;
    z = (r == 0); n = (r != 0) && r[31];
    case (op)
      2, 6: begin
        o = r - s - ((op == 6) ? 32'd1 : 32'd0);
        w = {1'b0, s} + {1'b0, o} + ((op == 6) ? 33'd1 : 33'd0);
        c = w[32];
        v = (s[31] == o[31]) && (r[31] != s[31]);
      end
      3, 7: begin
        t = r + s + ((op == 7) ? 32'd1 : 32'd0);
        w = {1'b0, t} - {1'b0, s} - ((op == 7) ? 33'd1 : 33'd0);
        c = w[32];
        v = (t[31] != s[31]) && (r[31] != t[31]);
      end
      4, 5: begin
        t = r + s;
        if (op == 4) begin
          z = (r[7:0] == 0); n = !z && r[7];
          c = ({1'b0, t[7:0]} - {1'b0, s[7:0]}) >> 8 != 0;
          v = (t[7] != s[7]) && (r[7] != t[7]);
        end else begin
          z = (r[15:0] == 0); n = !z && r[15];
          c = ({1'b0, t[15:0]} - {1'b0, s[15:0]}) >> 16 != 0;
          v = (t[15] != s[15]) && (r[15] != t[15]);
        end
      end
      8, 9, 10: begin
        if (s >= 32) begin
          z = (op != 10); n = (op == 10);
        end else begin
          if (op == 8) t = r << s;
          else if (op == 9) t = r >> s;
          else t = $signed(r) >>> s;
          z = (t == 0); n = (t != 0) && t[31];
        end
        if (s >= 1 && s <= 32) begin
          if (op == 8) begin x = {32'd0, 32'd0, r} << s; c = x[32]; end
          else begin x = {{32{(op == 10) && r[31]}}, r, 32'd0}; x = x >> s; c = x[31]; end
        end
      end
      default: ;
    endcase
    return {28'd0, n, z, v, c};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tag_of(input logic [3:0] op, output string t);
    case (op)
      0: t = "R2"; 1: t = "R4"; 2: t = "R5"; 3: t = "R6"; 4, 5: t = "R7";
      6, 7: t = "R8"; default: t = "R9/R10";
    endcase
  endtask

  task automatic load(input logic [3:0] op, input logic [31:0] s, input logic [31:0] r);
    string t;
    @(negedge clk);
    load_i = 1; op_i = op; src_i = s; res_i = r;
    @(negedge clk);
    load_i = 0;
    tag_of(op, t);
    chk({t, " flags"}, flags_o, ref_flags(op, s, r));
    chk("R2 cls", {28'd0, cls_o}, {28'd0, op});
  endtask

  task automatic flush(input logic [31:0] exp);
    @(negedge clk);
    flush_i = 1;
    @(negedge clk);
    flush_i = 0;
    chk("R11 res", res_o, exp);
    chk("R11 cls", {28'd0, cls_o}, 32'd0);
    chk("R11 pass", flags_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] e, s, r, keep;
    logic [3:0] op;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 flags", flags_o, 0);
    chk("R1 cls", {28'd0, cls_o}, 0);
    chk("R1 res", res_o, 0);
    chk("R1 err", {31'd0, err_o}, 0);

    load(0, 32'h1, 32'hDEAD_BEEF);            // R2 final passes through
    load(1, 32'h0, 32'h0);                   // R3 zero
    load(1, 32'h0, 32'h8000_0000);           // R3 negative
    load(2, 32'h1, 32'h8000_0000);           // R5 0x7fffffff+1
    load(2, 32'hFFFF_FFFF, 32'h0);           // R5 carry
    load(3, 32'h1, 32'h7FFF_FFFF);           // R6 0x80000000-1
    load(3, 32'h1, 32'hFFFF_FFFF);           // R6 borrow
    load(4, 32'hFFFF_FF01, 32'h1234_5680);   // R7 byte
    load(5, 32'h0001_0001, 32'hFFFF_0000);   // R7 word
    load(6, 32'h5, 32'h5);                   // R8 addx equal
    load(7, 32'hFFFF_FFFF, 32'h0);           // R8 subx
    foreach (e[i]) ;
    for (int k = 0; k < 3; k++) begin
      for (int j = 0; j < 7; j++) begin
        logic [31:0] cnts [7] = '{0, 1, 31, 32, 33, 64, 32'hFFFF_FFF0};
        load(4'(8 + k), cnts[j], 32'h8000_0001); // R9 R10
      end
    end

    load(3, 32'h2, 32'h1);
    flush(ref_flags(3, 32'h2, 32'h1));       // R11
    keep = res_o;
    flush(keep);                              // R11 final flush keeps

    load(2, 32'h1, 32'h5);
    @(negedge clk);
    load_i = 1; flush_i = 1; op_i = 1; src_i = 0; res_i = 32'h8000_0000;
    @(negedge clk);
    load_i = 0; flush_i = 0;
    chk("R11 load wins res", res_o, 32'h8000_0000);
    chk("R11 load wins cls", {28'd0, cls_o}, 1);

    @(negedge clk);
    load_i = 1; op_i = 4'd13; src_i = 32'h7; res_i = 32'h9;
    @(negedge clk);
    load_i = 0;
    chk("R12 err", {31'd0, err_o}, 1);
    chk("R12 res kept", res_o, 32'h8000_0000);
    chk("R12 cls kept", {28'd0, cls_o}, 1);
    chk("R12 flags kept", flags_o, ref_flags(1, 0, 32'h8000_0000));
    @(negedge clk);
    chk("R12 err clears", {31'd0, err_o}, 0);

    for (int i = 0; i < 600; i++) begin
      op = 4'($urandom_range(0, 10));
      s = $urandom;
      r = $urandom;
      if (op >= 8 && $urandom_range(0, 3) != 0) s = $urandom_range(0, 40);
      if ($urandom_range(0, 7) == 0) r = 0;
      load(op, s, r);
      if ($urandom_range(0, 3) == 0) begin
        e = ref_flags(op, s, r);
        flush(e);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule